// File: doc/BRIEF.md
# Per-Channel Interrupt Input Debounce Bank

This block filters the raw levels of four external interrupt pins before they reach the interrupt detector. Each channel can pass its pin straight through or hold its filtered output until the raw level has stayed at a new value for a chosen number of microsecond ticks. The bench drives the microsecond tick as a single-cycle strobe.

Software configures the channels through one 32-bit control word. Each channel owns one byte of that word. The word is never written directly. A write goes either to a set alias, where each 1 in the data sets the matching bit, or to a clear alias, where each 1 in the data clears the matching bit. The current configuration can be read at any time from a control view.

Each channel byte holds three things:
- an enable bit;
- a 4-bit index that picks a stable time from a fixed threshold table;
- a counter-restart bit that software pulses after servicing an interrupt. This bit clears itself after three clock cycles. While it is active, the channel's count is frozen at zero.

Top module: `dbnc_bank`

## Requirements
- R1: After a synchronous active-low reset, the control view reads all zeros and every filtered output is 0.
- R2: Channel n owns bits 8n+7 to 8n of the control word. In that byte, bit 0 is the enable, bit 1 is the counter restart and bits 7:4 are the time index. The view shows the enable and the index exactly as written.
- R3: A write with `cfg_clr`=0 (set alias) sets each enable and index bit that is 1 in the data. All other bits keep their values.
- R4: A write with `cfg_clr`=1 (clear alias) clears each enable and index bit that is 1 in the data. Writing 0xFF into a channel's byte returns that whole byte, including a pending restart, to zero on the next cycle.
- R5: Bits 3:2 of every channel byte are not stored and always read 0.
- R6: With the enable at 0, the filtered output equals the raw pin delayed by one clock cycle.
- R7: With the enable at 1, index 0 selects T0 ticks, index 1 selects T1 ticks, and index k from 2 to 6 selects TL·2^(k−2) ticks. The filtered output takes the raw level on the tick where the raw level has differed from the output for that many ticks.
- R8: If the raw level returns to the filtered output value for any cycle, the count starts again from zero.
- R9: An index from 7 to 15, or a table entry of 0, selects no filtering. The output then follows the raw pin with one cycle of latency.
- R10: Writing 1 to a channel's restart bit through the set alias makes that bit read 1 for exactly three cycles, after which it reads 0.
- R11: While a restart is active on an enabled, filtering channel, its count stays at zero and its output holds. Counting starts from zero once the restart ends.
- R12: The count advances only on cycles where `us_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_clr | input | 1 | 1 selects the clear alias, 0 selects the set alias |
| cfg_wdata | input | 32 | Write-1 data, one byte per channel |
| cfg_view | output | 32 | Current control word |
| us_tick | input | 1 | One-cycle microsecond strobe |
| pin_raw | input | 4 | Raw pin levels, already synchronous to clk |
| pin_filt | output | 4 | Filtered levels for the interrupt detector |

## Verification
The hardest case to reach from the ports is a restart that arrives while a count is already running. The raw level has to change in the same cycle the restart is written, so that one tick is counted before the freeze begins. The bench then checks that the output moves only after the three frozen cycles plus a complete new threshold, and not at the point the first count would have ended. The bench also sweeps every index on every channel with small table parameters. For each one it checks the exact cycle of the output change, computed from the index formula.

// File: rtl/dbnc_pkg.sv
// Package: shared widths, field positions and the threshold lookup for
// the debounce bank. Assumes four-bit time indices and byte-wide fields.
package dbnc_pkg;
    localparam int unsigned FIELD_W     = 8;
    localparam int unsigned IDX_W       = 4;
    localparam int unsigned EN_BIT      = 0;
    localparam int unsigned RST_BIT     = 1;
    localparam int unsigned IDX_LSB     = 4;
    localparam int unsigned HOLD_CYCLES = 3;
    localparam int unsigned HOLD_W      = 2;
    localparam int unsigned LAST_LONG   = 6;

    // Stored per-channel configuration
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             en;
    } chan_cfg_t;

    // Stable-time threshold in ticks for an index; 0 means no filtering
    function automatic logic [31:0] thresh_of(input logic [IDX_W-1:0] idx,
                                              input int unsigned t0,
                                              input int unsigned t1,
                                              input int unsigned tl);
        logic [31:0] r;
        if (idx == 4'd0)
            r = 32'(t0);
        else if (idx == 4'd1)
            r = 32'(t1);
        else if (32'(idx) <= LAST_LONG)
            r = 32'(tl) << (idx - 4'd2);
        else
            r = 32'd0;
        return r;
    endfunction
endpackage

// File: rtl/dbnc_cfg_regs.sv
// Module: control word storage with write-1 set and clear aliases.
// Keeps enable and index per channel and a self-clearing restart countdown.
// Assumes one write per cycle; reserved bits 3:2 of each byte are dropped.
module dbnc_cfg_regs
    import dbnc_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned WORD_W = NUM_CH * FIELD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_clr,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output chan_cfg_t           cfg   [NUM_CH],
    output logic [NUM_CH-1:0]   hold_on,
    output logic [WORD_W-1:0]   cfg_view
);
    logic unused_rsv;
    logic [NUM_CH*2-1:0] rsv_bits;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [FIELD_W-1:0] wbyte;
        logic [HOLD_W-1:0]  hold_q, hold_d;
        chan_cfg_t          cfg_q, cfg_d;

        assign wbyte = cfg_wdata[g*FIELD_W +: FIELD_W];
        assign rsv_bits[g*2 +: 2] = wbyte[3:2];

        // Next-state for enable, index and restart countdown
        always_comb begin
            cfg_d  = cfg_q;
            hold_d = (hold_q != '0) ? hold_q - 1'b1 : hold_q;
            if (cfg_we) begin
                if (cfg_clr) begin
                    if (wbyte[EN_BIT])  cfg_d.en = 1'b0;
                    cfg_d.idx = cfg_q.idx & ~wbyte[IDX_LSB +: IDX_W];
                    if (wbyte[RST_BIT]) hold_d = '0;
                end else begin
                    if (wbyte[EN_BIT])  cfg_d.en = 1'b1;
                    cfg_d.idx = cfg_q.idx | wbyte[IDX_LSB +: IDX_W];
                    if (wbyte[RST_BIT]) hold_d = HOLD_W'(HOLD_CYCLES);
                end
            end
        end

        // Configuration state register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q  <= '0;
                hold_q <= '0;
            end else begin
                cfg_q  <= cfg_d;
                hold_q <= hold_d;
            end
        end

        assign cfg[g]     = cfg_q;
        assign hold_on[g] = (hold_q != '0);
        assign cfg_view[g*FIELD_W +: FIELD_W] =
            {cfg_q.idx, 2'b00, hold_on[g], cfg_q.en};

        // R4
        clear_wipes_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_clr && wbyte == 8'hFF) |=> (cfg_view[g*FIELD_W +: FIELD_W] == 8'h00));

        // R10
        restart_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_clr && wbyte[RST_BIT]) |=> hold_on[g]);
    end

    assign unused_rsv = ^rsv_bits;
endmodule

// File: rtl/dbnc_channel.sv
// Module: one debounce filter. When filtering, the output takes the raw
// level once it has differed for the selected number of ticks; otherwise
// it follows the raw level one cycle late. Assumes raw is synchronous.
module dbnc_channel
    import dbnc_pkg::*;
#(
    parameter int unsigned T0 = 500,
    parameter int unsigned T1 = 1000,
    parameter int unsigned TL = 16000,
    localparam int unsigned MAX_T = TL << (LAST_LONG - 2),
    localparam int unsigned CNT_W = $clog2(MAX_T + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      raw,
    input  logic      tick,
    input  chan_cfg_t cfg,
    input  logic      hold,
    output logic      filt
);
    logic [31:0]      thr;
    logic             filtering;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      cnt_inc;

    // Threshold lookup and filter-active decision
    always_comb begin
        thr       = thresh_of(cfg.idx, T0, T1, TL);
        filtering = cfg.en && (thr != 32'd0);
        cnt_inc   = 32'(cnt_q) + 32'd1;
    end

    // Stable-time counter and filtered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            filt  <= 1'b0;
        end else if (!filtering) begin
            cnt_q <= '0;
            filt  <= raw;
        end else if (hold || raw == filt) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_inc >= thr) begin
                cnt_q <= '0;
                filt  <= raw;
            end else begin
                cnt_q <= CNT_W'(cnt_inc);
            end
        end
    end

    // R6
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (filt == $past(raw)));

    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filtering && hold) |=> ($stable(filt) && cnt_q == '0));

    // R8
    equal_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filtering && raw == filt) |=> ($stable(filt) && cnt_q == '0));

    // R12
    no_tick_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filtering && !tick) |=> $stable(filt));
endmodule

// File: rtl/dbnc_bank.sv
// Module: top of the debounce bank. Ties the control word storage to one
// filter per channel. Assumes pin_raw is already synchronised to clk.
module dbnc_bank
    import dbnc_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned T0     = 500,
    parameter int unsigned T1     = 1000,
    parameter int unsigned TL     = 16000,
    localparam int unsigned WORD_W = NUM_CH * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_clr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_view,
    input  logic              us_tick,
    input  logic [NUM_CH-1:0] pin_raw,
    output logic [NUM_CH-1:0] pin_filt
);
    chan_cfg_t         cfg [NUM_CH];
    logic [NUM_CH-1:0] hold_on;

    dbnc_cfg_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_clr   (cfg_clr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .hold_on   (hold_on),
        .cfg_view  (cfg_view)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flt
        dbnc_channel #(.T0(T0), .T1(T1), .TL(TL)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (pin_raw[g]),
            .tick  (us_tick),
            .cfg   (cfg[g]),
            .hold  (hold_on[g]),
            .filt  (pin_filt[g])
        );
    end
endmodule

// File: tb/test_dbnc_bank.sv
module test_dbnc_bank;
    localparam int unsigned T0 = 3, T1 = 5, TL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_clr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_view;
    logic        us_tick = 1'b1;
    logic [3:0]  pin_raw = '0;
    logic [3:0]  pin_filt;
    int          nchk = 0, nerr = 0;
    bit          done = 1'b0;

    dbnc_bank #(.NUM_CH(4), .T0(T0), .T1(T1), .TL(TL)) i_dbnc_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clr(cfg_clr),
        .cfg_wdata(cfg_wdata), .cfg_view(cfg_view), .us_tick(us_tick),
        .pin_raw(pin_raw), .pin_filt(pin_filt));

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int unsigned exp_thr(input int unsigned idx);
        if (idx == 0) return T0;
        if (idx == 1) return T1;
        if (idx <= 6) return TL * (2 ** (idx - 2));
        return 0;
    endfunction

    // Called at a negedge; returns at the negedge after the write edge
    task automatic cfg_write(input logic clr, input logic [31:0] d);
        cfg_we = 1'b1; cfg_clr = clr; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    // Drive a new raw level on channel c and check the exact change cycle
    task automatic step(input int c, input logic v, input int unsigned thr, input string tag);
        pin_raw[c] = v;
        if (thr == 0) begin
            chk({tag, " before"}, 32'(pin_filt[c]), 32'(!v));
            @(negedge clk);
            chk({tag, " after"}, 32'(pin_filt[c]), 32'(v));
        end else begin
            repeat (thr - 1) @(negedge clk);
            chk({tag, " before"}, 32'(pin_filt[c]), 32'(!v));
            @(negedge clk);
            chk({tag, " after"}, 32'(pin_filt[c]), 32'(v));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 view", cfg_view, 32'h0);
        chk("R1 filt", 32'(pin_filt), 32'h0);

        // R3 / R4 / R5 alias semantics on channel 2
        cfg_write(1'b0, 32'h0031_0000);
        cfg_write(1'b0, 32'h0000_0011);
        chk("R3 set keeps other byte", cfg_view, 32'h0031_0011);
        cfg_write(1'b0, 32'h0040_0000);
        chk("R3 set ORs", cfg_view, 32'h0071_0011);
        cfg_write(1'b1, 32'h0010_0000);
        chk("R4 clear bits", cfg_view, 32'h0061_0011);
        cfg_write(1'b0, 32'h0C0C_0C0C);
        chk("R5 reserved read 0", cfg_view, 32'h0061_0011);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        chk("R4 clear all", cfg_view, 32'h0);

        // R6 disabled pass-through on channel 2
        step(2, 1'b1, 0, "R6 rise");
        step(2, 1'b0, 0, "R6 fall");

        // R2 / R7 / R9 sweep of every index on every channel
        for (int c = 0; c < 4; c++) begin
            for (int idx = 0; idx < 16; idx++) begin
                logic [31:0] word;
                word = 32'((idx << 4) | 1) << (8 * c);
                cfg_write(1'b1, 32'hFFFF_FFFF);
                cfg_write(1'b0, word);
                chk($sformatf("R2 view c%0d i%0d", c, idx), cfg_view, word);
                @(negedge clk);
                step(c, 1'b1, exp_thr(idx), $sformatf("%s c%0d i%0d rise", (idx > 6) ? "R9" : "R7", c, idx));
                step(c, 1'b0, exp_thr(idx), $sformatf("%s c%0d i%0d fall", (idx > 6) ? "R9" : "R7", c, idx));
                chk("R2 others quiet", 32'(pin_filt), 32'h0);
            end
        end

        // R8 bounce on channel 0, index 0 (3 ticks)
        cfg_write(1'b1, 32'hFFFF_FFFF);
        cfg_write(1'b0, 32'h0000_0001);
        pin_raw[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 setup", 32'(pin_filt[0]), 32'h1);
        pin_raw[0] = 1'b0;
        repeat (2) @(negedge clk);
        pin_raw[0] = 1'b1;
        @(negedge clk);
        chk("R8 bounce held", 32'(pin_filt[0]), 32'h1);
        pin_raw[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 restarted", 32'(pin_filt[0]), 32'h1);
        @(negedge clk);
        chk("R8 flip", 32'(pin_filt[0]), 32'h0);

        // R12 ticks every other cycle
        pin_raw[0] = 1'b1; us_tick = 1'b0;
        @(negedge clk); us_tick = 1'b1;
        @(negedge clk); us_tick = 1'b0;
        @(negedge clk); us_tick = 1'b1;
        @(negedge clk); us_tick = 1'b0;
        @(negedge clk);
        chk("R12 two ticks", 32'(pin_filt[0]), 32'h0);
        us_tick = 1'b1;
        @(negedge clk);
        chk("R12 third tick", 32'(pin_filt[0]), 32'h1);

        // R10 / R11 restart during a running count on channel 1
        cfg_write(1'b0, 32'h0000_0100);
        @(negedge clk);
        pin_raw[1] = 1'b1;
        cfg_write(1'b0, 32'h0000_0200);
        chk("R10 restart cyc1", cfg_view[9], 32'h1);
        @(negedge clk);
        chk("R10 restart cyc2", cfg_view[9], 32'h1);
        @(negedge clk);
        chk("R10 restart cyc3", cfg_view[9], 32'h1);
        @(negedge clk);
        chk("R10 self clear", cfg_view[9], 32'h0);
        chk("R11 held", 32'(pin_filt[1]), 32'h0);
        repeat (2) @(negedge clk);
        chk("R11 recount", 32'(pin_filt[1]), 32'h0);
        @(negedge clk);
        chk("R11 flip", 32'(pin_filt[1]), 32'h1);

        // R4 clear wipes a pending restart
        cfg_write(1'b0, 32'h0000_0200);
        chk("R10 pending", cfg_view[15:8], 32'h03);
        cfg_write(1'b1, 32'h0000_FF00);
        chk("R4 wipes restart", cfg_view[15:8], 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule